// File: doc/BRIEF.md
# Bit-Band Alias Translator

This unit sits between one requesting master and a word-organised target space. Every 32-bit word of a configurable alias window stands for exactly one bit of the target region. A read of an alias word returns that bit in data bit 0, with every other bit zero. A write to an alias word sets the bit when data bit 0 is 1 and clears it when data bit 0 is 0. The write is carried out as a read of the target word followed by a write of the same word with only that bit changed. No other target access can fall between the two. Any address outside the alias window is forwarded to the target with its address, direction and data unchanged.

Both sides use a valid/ready request handshake. The master starts a request with `req_valid` and it is taken on a cycle where `req_ready` is high. Read data comes back as a one-cycle `rsp_valid` pulse. On the target side, reads are answered through `tgt_rvalid`/`tgt_rdata`, and writes have no response. The translator handles one request at a time. It holds `req_ready` low while a request is in progress, and that blocking is what makes each alias write atomic. The alias base, the target base, the window size and the address width are parameters.

Top module: `bitband_xlate`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1 and both `tgt_valid` and `rsp_valid` are 0.
- R2: A request whose address is outside the alias window produces exactly one target access with the same byte address, direction and write data. For a read, `rsp_rdata` equals the returned target word.
- R3: An address A is an alias address exactly when ALIAS_BASE <= A < ALIAS_BASE + ALIAS_BYTES. The words just below and just above the window pass through unchanged.
- R4: For an alias address A, let rel = A - ALIAS_BASE. The target byte offset is rel/32 and the bit within that byte is (rel/4) mod 8. The target word address is TARGET_BASE plus the byte offset with its two low bits cleared. The bit index within the word is (byte offset mod 4)*8 + bit-in-byte.
- R5: An alias read makes exactly one target read and no target write. It returns the selected bit in `rsp_rdata[0]`, with `rsp_rdata[31:1]` equal to 0.
- R6: An alias write with `req_wdata[0]`=1 sets the selected bit and with `req_wdata[0]`=0 clears it. `req_wdata[31:1]` is ignored, and every other bit of the target word keeps its value.
- R7: An alias write makes exactly two target accesses to the same word address: first a read, then a write. `req_ready` stays low from acceptance until that write has been accepted.
- R8: While `tgt_valid` is high and `tgt_ready` is low, `tgt_valid`, `tgt_addr`, `tgt_we` and `tgt_wdata` hold their values into the next cycle.
- R9: Address bits [1:0] of an alias request do not affect which bit is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Master request present |
| req_ready | output | 1 | Translator can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Master byte address |
| req_wdata | input | 32 | Master write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Read data to master |
| tgt_valid | output | 1 | Target request present |
| tgt_ready | input | 1 | Target accepts request |
| tgt_we | output | 1 | Target write enable |
| tgt_addr | output | ADDR_W | Target byte address (word aligned for alias accesses) |
| tgt_wdata | output | 32 | Target write data |
| tgt_rvalid | input | 1 | Target read data valid |
| tgt_rdata | input | 32 | Target read data |

## Verification
A wrong bit index or word offset in the decoder shows up as soon as the affected alias read completes. That read either returns the wrong bit or goes to the wrong target word, and both are visible after the first target read. A fault in the merge logic shows up on the target write data of the same alias write, as a second changed bit or an unchanged target bit. A sequencer that leaves its busy state too early, or that drops a stalled request, shows up as a missing target access or an extra one within the same transaction. An exhaustive sweep of every alias bit against a reference memory exposes each of these faults within one request.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_WRITE
  } xl_state_e;

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
  import bitband_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4400_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BYTES = 32'h0200_0000,
  parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h4000_0000
) (
  input  logic [ADDR_W-3:0] word_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] tgt_word_addr,
  output logic [IDX_W-1:0]  bit_idx
);

  localparam logic [ADDR_W-3:0] BASE_W = ALIAS_BASE[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] SPAN_W = ALIAS_BYTES[ADDR_W-1:2];

  logic [ADDR_W-3:0] rel;
  logic [ADDR_W-6:0] tword;

  // rel counts alias words; [2:0] bit in byte, [4:3] byte lane, above: target word
  always_comb begin
    rel           = word_addr - BASE_W;
    hit           = (word_addr >= BASE_W) && (rel < SPAN_W);
    tword         = rel[ADDR_W-3:5];
    tgt_word_addr = TARGET_BASE + {3'b000, tword, 2'b00};
    bit_idx       = rel[4:0];
  end

endmodule

// File: rtl/bb_bit_pick.sv
module bb_bit_pick #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  word_i,
  input  logic [IW-1:0] idx,
  output logic          bit_o
);

  always_comb bit_o = word_i[idx];

endmodule

// File: rtl/bb_bit_insert.sv
module bb_bit_insert #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  word_i,
  input  logic [IW-1:0] idx,
  input  logic          val,
  output logic [W-1:0]  word_o
);

  for (genvar i = 0; i < W; i++) begin : g_lane
    localparam logic [IW-1:0] POS = IW'(i);
    assign word_o[i] = (idx == POS) ? val : word_i[i];
  end

endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bitband_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] ALIAS_BASE  = 32'h4400_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BYTES = 32'h0200_0000,
  parameter logic [ADDR_W-1:0] TARGET_BASE = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic              tgt_we,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [WORD_W-1:0] tgt_wdata,
  input  logic              tgt_rvalid,
  input  logic [WORD_W-1:0] tgt_rdata
);

  xl_state_e         state_q, state_d;
  logic              we_q, alias_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q, rd_q;
  logic [IDX_W-1:0]  idx_q;

  logic              hit;
  logic [ADDR_W-1:0] dec_addr;
  logic [IDX_W-1:0]  dec_idx;
  logic              picked;
  logic [WORD_W-1:0] merged;
  logic              accept, rd_en, rmw;

  bb_window_decode #(
    .ADDR_W(ADDR_W), .ALIAS_BASE(ALIAS_BASE),
    .ALIAS_BYTES(ALIAS_BYTES), .TARGET_BASE(TARGET_BASE)
  ) u_dec (
    .word_addr(req_addr[ADDR_W-1:2]), .hit(hit),
    .tgt_word_addr(dec_addr), .bit_idx(dec_idx)
  );

  bb_bit_pick #(.W(WORD_W)) u_pick (
    .word_i(tgt_rdata), .idx(idx_q), .bit_o(picked)
  );

  bb_bit_insert #(.W(WORD_W)) u_ins (
    .word_i(rd_q), .idx(idx_q), .val(data_q[0]), .word_o(merged)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_en     = (state_q == ST_WAIT) && tgt_rvalid;
  assign rmw       = alias_q && we_q;

  assign tgt_valid = (state_q == ST_ISSUE) || (state_q == ST_WRITE);
  assign tgt_we    = (state_q == ST_WRITE) || ((state_q == ST_ISSUE) && we_q && !alias_q);
  assign tgt_addr  = addr_q;
  assign tgt_wdata = (state_q == ST_WRITE) ? merged : data_q;

  assign rsp_valid = rd_en && !rmw;
  assign rsp_rdata = alias_q ? {{(WORD_W-1){1'b0}}, picked} : tgt_rdata;

  // next-state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
      ST_ISSUE: if (tgt_ready) state_d = tgt_we ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (tgt_rvalid) state_d = rmw ? ST_WRITE : ST_IDLE;
      ST_WRITE: if (tgt_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      alias_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
    end else if (accept) begin
      we_q    <= req_we;
      alias_q <= hit;
      addr_q  <= hit ? dec_addr : req_addr;
      data_q  <= hit ? {{(WORD_W-1){1'b0}}, req_wdata[0]} : req_wdata;
      idx_q   <= dec_idx;
    end
  end

  // target word capture for the merge step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= tgt_rdata;
  end

  assert_rmw_reads_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && req_we) |=> (tgt_valid && !tgt_we));

  assert_rmw_write_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rmw) |=> (tgt_valid && tgt_we && $stable(tgt_addr)));

  assert_one_bit_changed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE) |-> ($countones(tgt_wdata ^ rd_q) <= 1));

  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_ready) |=>
      (tgt_valid && $stable(tgt_addr) && $stable(tgt_we) && $stable(tgt_wdata)));

  assert_zero_extend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && alias_q) |-> (rsp_rdata[WORD_W-1:1] == '0));

  assert_pass_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (tgt_valid && tgt_addr == $past(req_addr)));

endmodule

// File: tb/sim_bitband_xlate.sv
`timescale 1ns/1ps
module sim_bitband_xlate;

  localparam int          AW = 16;
  localparam logic [15:0] AB = 16'h8000;
  localparam logic [15:0] AS = 16'h0800;
  localparam logic [15:0] TB = 16'h0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_we;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        tgt_valid, tgt_ready, tgt_we, tgt_rvalid;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata, tgt_rdata;

  always #2 clk = ~clk;

  bitband_xlate #(.ADDR_W(AW), .ALIAS_BASE(AB), .ALIAS_BYTES(AS), .TARGET_BASE(TB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_we(tgt_we),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_rvalid(tgt_rvalid), .tgt_rdata(tgt_rdata)
  );

  // target model: 64 words indexed by addr[7:2], stalls from an LFSR
  logic [31:0] mem [64];
  logic [7:0]  lf;
  int          op_total, hold_viol;
  logic        op_we_log [256];
  logic [15:0] op_addr_log [256];
  logic [31:0] op_data_log [256];
  logic        pend;
  logic [15:0] pend_addr;

  assign tgt_ready = lf[0] | lf[1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf <= 8'h5A; tgt_rvalid <= 1'b0; op_total <= 0; hold_viol <= 0; pend <= 1'b0;
      pend_addr <= '0;
    end else begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tgt_rvalid <= 1'b0;
      if (pend && !(tgt_valid && tgt_addr == pend_addr)) hold_viol <= hold_viol + 1;
      pend      <= tgt_valid && !tgt_ready;
      pend_addr <= tgt_addr;
      if (tgt_valid && tgt_ready) begin
        op_we_log[op_total % 256]   <= tgt_we;
        op_addr_log[op_total % 256] <= tgt_addr;
        op_data_log[op_total % 256] <= tgt_wdata;
        op_total <= op_total + 1;
        if (tgt_we) mem[tgt_addr[7:2]] <= tgt_wdata;
        else begin
          tgt_rvalid <= 1'b1;
          tgt_rdata  <= mem[tgt_addr[7:2]];
        end
      end
    end
  end

  int          n_chk = 0, n_bad = 0;
  logic [31:0] ref_mem [64];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [15:0] a, input logic [31:0] d,
                      output logic [31:0] r, output int start, output int ops);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start = op_total;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    r = '0;
    forever begin
      @(negedge clk);
      if (rsp_valid) r = rsp_rdata;
      if (req_ready) break;
    end
    ops = op_total - start;
  endtask

  // alias address -> word index and bit index, from the byte-offset formula
  task automatic locate(input logic [15:0] a, output int w, output int b);
    int rel, byte_off, bitn;
    rel      = int'(a - AB);
    byte_off = rel / 32;
    bitn     = (rel / 4) % 8;
    w        = byte_off / 4;
    b        = (byte_off % 4) * 8 + bitn;
  endtask

  logic [31:0] r;
  int st, ops, w, b;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'b0, req_ready}, 32'd1);
    check("R1 tgt_valid in reset", {31'b0, tgt_valid}, 32'd0);
    check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    check("R1 tgt_valid after reset", {31'b0, tgt_valid}, 32'd0);

    // R2: direct writes then reads of all target words
    for (int i = 0; i < 64; i++) begin
      ref_mem[i] = (32'(i + 1) * 32'h9E37_79B9) ^ (32'(i) << 3);
      xfer(1'b1, 16'(i * 4), ref_mem[i], r, st, ops);
      check("R2 pass write op count", 32'(ops), 32'd1);
      check("R2 pass write addr", {16'b0, op_addr_log[st % 256]}, 32'(i * 4));
      check("R2 pass write data", op_data_log[st % 256], ref_mem[i]);
    end
    for (int i = 0; i < 64; i++) begin
      xfer(1'b0, 16'(i * 4), 32'hFFFF_FFFF, r, st, ops);
      check("R2 pass read data", r, ref_mem[i]);
      check("R2 pass read is read", {31'b0, op_we_log[st % 256]}, 32'd0);
    end

    // R4/R5: every alias bit read
    for (int k = 0; k < 512; k++) begin
      locate(AB + 16'(k * 4), w, b);
      xfer(1'b0, AB + 16'(k * 4), 32'h0, r, st, ops);
      check("R5 alias read value", r, {31'b0, ref_mem[w][b]});
      check("R5 alias read op count", 32'(ops), 32'd1);
      check("R5 alias read no write", {31'b0, op_we_log[st % 256]}, 32'd0);
      check("R4 alias word addr", {16'b0, op_addr_log[st % 256]}, 32'(TB) + 32'(w * 4));
    end

    // R3: window edges
    xfer(1'b0, AB, 32'h0, r, st, ops);
    check("R3 first alias maps to word 0", {16'b0, op_addr_log[st % 256]}, 32'(TB));
    check("R3 first alias bit 0", r, {31'b0, ref_mem[0][0]});
    xfer(1'b0, AB + AS - 16'd4, 32'h0, r, st, ops);
    check("R3 last alias maps to word 15", {16'b0, op_addr_log[st % 256]}, 32'(TB) + 32'd60);
    check("R3 last alias bit 31", r, {31'b0, ref_mem[15][31]});
    xfer(1'b0, AB - 16'd4, 32'h0, r, st, ops);
    check("R3 below window passes addr", {16'b0, op_addr_log[st % 256]}, 32'(AB - 16'd4));
    check("R3 below window passes data", r, ref_mem[63]);
    xfer(1'b0, AB + AS, 32'h0, r, st, ops);
    check("R3 above window passes addr", {16'b0, op_addr_log[st % 256]}, 32'(AB + AS));
    check("R3 above window passes data", r, ref_mem[0]);

    // R6/R7: alias writes of every bit, with direct writes interleaved
    for (int k = 0; k < 512; k++) begin
      logic        v;
      logic [31:0] d;
      v = 1'((k * 3) >> 1) ^ ref_mem[k >> 5][k & 31];
      d = (32'(k) * 32'h0100_0193) ^ 32'hA5A5_0000;
      d[0] = v;
      locate(AB + 16'(k * 4), w, b);
      xfer(1'b1, AB + 16'(k * 4), d, r, st, ops);
      ref_mem[w][b] = v;
      check("R7 rmw op count", 32'(ops), 32'd2);
      check("R7 rmw first is read", {31'b0, op_we_log[st % 256]}, 32'd0);
      check("R7 rmw second is write", {31'b0, op_we_log[(st + 1) % 256]}, 32'd1);
      check("R7 rmw same word", {16'b0, op_addr_log[(st + 1) % 256]}, 32'(w * 4));
      check("R6 rmw write word", op_data_log[(st + 1) % 256], ref_mem[w]);
      if (k % 37 == 5) begin
        int j;
        j = (k * 13) % 64;
        ref_mem[j] = ref_mem[j] ^ (32'(k) * 32'h2545_F491);
        xfer(1'b1, 16'(j * 4), ref_mem[j], r, st, ops);
        check("R2 interleaved pass write", 32'(ops), 32'd1);
      end
    end
    for (int i = 0; i < 64; i++) begin
      xfer(1'b0, 16'(i * 4), 32'h0, r, st, ops);
      check("R6 final target word", r, ref_mem[i]);
    end

    // R9: low address bits ignored on alias accesses
    for (int k = 0; k < 512; k += 29) begin
      for (int lo = 1; lo < 4; lo++) begin
        locate(AB + 16'(k * 4), w, b);
        xfer(1'b0, AB + 16'(k * 4 + lo), 32'h0, r, st, ops);
        check("R9 low bits ignored read", r, {31'b0, ref_mem[w][b]});
        check("R9 low bits ignored addr", {16'b0, op_addr_log[st % 256]}, 32'(w * 4));
      end
    end

    check("R8 stalled request held", 32'(hold_viol), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule